// File: doc/BRIEF.md
# Out-of-order operand-wait station with result wakeup

This block parks renamed instructions until both of their source operands are known, and then hands them one at a time to an execution unit. Every slot keeps an operation code, two source fields, the physical register that will receive the result and the index of the instruction's reorder-buffer slot. A source field holds either a finished operand value or, while the operand is still being computed, the physical tag of the instruction that will produce it. A one-bit flag beside each field tells the two cases apart.

Finished results arrive on a broadcast bus as a tag and a value. Every waiting source whose tag matches takes the value and marks itself as present, including a source that is being written by a dispatch in that same cycle. Each cycle, a selector looks at all slots whose two flags are set and picks the one that entered the station earliest. The pick moves into a registered issue stage with a valid/ready handshake, and its slot is released at once.

Upstream logic watches the dispatch ready output and offers at most one instruction per cycle. The reorder buffer and the functional units sit outside this block.

Top module: `rsv_station`

## Requirements
- R1: An instruction offered with `disp_valid` high while `disp_ready` is high is written into a free slot on that clock edge. Nothing is written while `disp_ready` is low.
- R2: A source flag of 1 means the field holds the operand value. A flag of 0 means bits [TAG_W-1:0] of the field hold the producer's tag, and the upper bits are ignored.
- R3: A broadcast with `bc_valid` high writes `bc_value` into every waiting source whose tag equals `bc_tag` and sets that source's flag. Sources with other tags, and sources whose flag is already set, keep their contents.
- R4: An instruction reaches the issue port only after both of its source flags are set.
- R5: If a broadcast and a dispatch happen in the same cycle and the dispatched source waits on the broadcast tag, that source is stored as the broadcast value with its flag set.
- R6: When several slots are ready, the one dispatched earliest is issued first, whatever the slot positions are.
- R7: A slot is released on the edge where its instruction moves into the issue stage, and it can be reused by the next dispatch.
- R8: `disp_ready` is low exactly when all SLOTS slots are occupied.
- R9: While `iss_valid` is high and `iss_ready` is low, the issue outputs keep their values.
- R10: If the issue stage is empty or being drained, an instruction dispatched with both sources present on edge k appears on the issue port after edge k+1, and not after edge k.
- R11: After reset, no slot is occupied, `iss_valid` is low and `disp_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| disp_valid | input | 1 | Dispatch offer |
| disp_ready | output | 1 | A free slot exists |
| disp_op | input | OP_W | Operation code |
| disp_s1_have | input | 1 | Source 1 field is a value (1) or a tag (0) |
| disp_s1 | input | DATA_W | Source 1 value or producer tag |
| disp_s2_have | input | 1 | Source 2 field is a value (1) or a tag (0) |
| disp_s2 | input | DATA_W | Source 2 value or producer tag |
| disp_dst | input | TAG_W | Destination physical tag |
| disp_rob | input | ROB_W | Reorder-buffer index |
| bc_valid | input | 1 | Result broadcast valid |
| bc_tag | input | TAG_W | Tag of broadcast result |
| bc_value | input | DATA_W | Broadcast result value |
| iss_valid | output | 1 | Issue stage holds an instruction |
| iss_ready | input | 1 | Execution unit accepts the issue stage |
| iss_op | output | OP_W | Issued operation code |
| iss_s1 | output | DATA_W | Issued source 1 value |
| iss_s2 | output | DATA_W | Issued source 2 value |
| iss_dst | output | TAG_W | Issued destination tag |
| iss_rob | output | ROB_W | Issued reorder-buffer index |

## Verification
A dispatch is captured on the edge that follows its offer, and `disp_ready` reflects that slot from the same edge on. A broadcast sets the flags on its own edge. The selected instruction shows on the issue port one edge later, so a ready dispatch is visible two edges after it is offered and a woken instruction two edges after its broadcast. The bench drives inputs at the falling edge and samples outputs at a falling edge. Each expected value is read exactly that many falling edges after its stimulus: directed sequences for the full, hold, same-cycle and age-order cases, and a random run checked against a scoreboard keyed by reorder-buffer index.

// File: rtl/rsv_pkg.sv
package rsv_pkg;
  localparam int unsigned RS_SLOTS_DEFAULT = 8;

  // state of one source operand field
  typedef enum logic {
    SRC_PENDING = 1'b0,
    SRC_VALUE   = 1'b1
  } src_state_e;
endpackage

// File: rtl/rsv_operand.sv
// One source operand: value-or-tag storage with broadcast capture.
module rsv_operand #(
  parameter int DATA_W = 16,
  parameter int TAG_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              in_have,
  input  logic [DATA_W-1:0] in_field,
  input  logic              bc_valid,
  input  logic [TAG_W-1:0]  bc_tag,
  input  logic [DATA_W-1:0] bc_value,
  output logic              have,
  output logic [DATA_W-1:0] field
);
  import rsv_pkg::*;

  src_state_e        state_q;
  logic [DATA_W-1:0] field_q;
  logic              hit_new;
  logic              hit_old;

  // capture on the same edge as the dispatch write
  assign hit_new = bc_valid && !in_have && (in_field[TAG_W-1:0] == bc_tag);
  // capture for a field already waiting
  assign hit_old = bc_valid && (state_q == SRC_PENDING) && (field_q[TAG_W-1:0] == bc_tag);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SRC_PENDING;
    end else if (load) begin
      state_q <= (in_have || hit_new) ? SRC_VALUE : SRC_PENDING;
    end else if (hit_old) begin
      state_q <= SRC_VALUE;
    end
  end

  always_ff @(posedge clk) begin
    if (load) begin
      field_q <= hit_new ? bc_value : in_field;
    end else if (hit_old) begin
      field_q <= bc_value;
    end
  end

  assign have  = (state_q == SRC_VALUE);
  assign field = field_q;
endmodule

// File: rtl/rsv_slot.sv
// One station slot: occupancy, payload and two operand fields.
module rsv_slot #(
  parameter int OP_W   = 4,
  parameter int DATA_W = 16,
  parameter int TAG_W  = 6,
  parameter int ROB_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              alloc,
  input  logic              release_en,
  input  logic [OP_W-1:0]   d_op,
  input  logic              d_s1_have,
  input  logic [DATA_W-1:0] d_s1,
  input  logic              d_s2_have,
  input  logic [DATA_W-1:0] d_s2,
  input  logic [TAG_W-1:0]  d_dst,
  input  logic [ROB_W-1:0]  d_rob,
  input  logic              bc_valid,
  input  logic [TAG_W-1:0]  bc_tag,
  input  logic [DATA_W-1:0] bc_value,
  output logic              occupied,
  output logic              ready,
  output logic [OP_W-1:0]   op,
  output logic [DATA_W-1:0] s1,
  output logic [DATA_W-1:0] s2,
  output logic [TAG_W-1:0]  dst,
  output logic [ROB_W-1:0]  rob
);
  logic             occ_q;
  logic             have1;
  logic             have2;
  logic [OP_W-1:0]  op_q;
  logic [TAG_W-1:0] dst_q;
  logic [ROB_W-1:0] rob_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      occ_q <= 1'b0;
    end else if (alloc) begin
      occ_q <= 1'b1;
    end else if (release_en) begin
      occ_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (alloc) begin
      op_q  <= d_op;
      dst_q <= d_dst;
      rob_q <= d_rob;
    end
  end

  rsv_operand #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_src1 (
    .clk(clk), .rst(rst), .load(alloc),
    .in_have(d_s1_have), .in_field(d_s1),
    .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_value(bc_value),
    .have(have1), .field(s1)
  );

  rsv_operand #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_src2 (
    .clk(clk), .rst(rst), .load(alloc),
    .in_have(d_s2_have), .in_field(d_s2),
    .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_value(bc_value),
    .have(have2), .field(s2)
  );

  assign occupied = occ_q;
  assign ready    = occ_q & have1 & have2;
  assign op       = op_q;
  assign dst      = dst_q;
  assign rob      = rob_q;
endmodule

// File: rtl/rsv_age_pick.sv
// Relative-age matrix; grants the earliest-dispatched requester.
module rsv_age_pick #(
  parameter int SLOTS = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SLOTS-1:0] alloc_oh,
  input  logic [SLOTS-1:0] occ,
  input  logic [SLOTS-1:0] req,
  output logic [SLOTS-1:0] grant_oh
);
  // older_q[a][b] set: slot a entered before slot b
  logic [SLOTS-1:0][SLOTS-1:0] older_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      older_q <= '0;
    end else begin
      for (int k = 0; k < SLOTS; k++) begin
        if (alloc_oh[k]) begin
          for (int j = 0; j < SLOTS; j++) begin
            older_q[k][j] <= 1'b0;
            if (j != k) older_q[j][k] <= occ[j];
          end
        end
      end
    end
  end

  for (genvar i = 0; i < SLOTS; i++) begin : g_col
    logic [SLOTS-1:0] beaten_by;
    for (genvar j = 0; j < SLOTS; j++) begin : g_row
      if (i == j) begin : g_self
        assign beaten_by[j] = 1'b0;
      end else begin : g_other
        assign beaten_by[j] = older_q[j][i];
      end
    end
    assign grant_oh[i] = req[i] && ~|(beaten_by & req);
  end
endmodule

// File: rtl/rsv_station.sv
// Operand-wait station: dispatch, broadcast wakeup, oldest-ready issue.
module rsv_station #(
  parameter int SLOTS  = rsv_pkg::RS_SLOTS_DEFAULT,
  parameter int OP_W   = 4,
  parameter int DATA_W = 16,
  parameter int TAG_W  = 6,
  parameter int ROB_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              disp_valid,
  output logic              disp_ready,
  input  logic [OP_W-1:0]   disp_op,
  input  logic              disp_s1_have,
  input  logic [DATA_W-1:0] disp_s1,
  input  logic              disp_s2_have,
  input  logic [DATA_W-1:0] disp_s2,
  input  logic [TAG_W-1:0]  disp_dst,
  input  logic [ROB_W-1:0]  disp_rob,
  input  logic              bc_valid,
  input  logic [TAG_W-1:0]  bc_tag,
  input  logic [DATA_W-1:0] bc_value,
  output logic              iss_valid,
  input  logic              iss_ready,
  output logic [OP_W-1:0]   iss_op,
  output logic [DATA_W-1:0] iss_s1,
  output logic [DATA_W-1:0] iss_s2,
  output logic [TAG_W-1:0]  iss_dst,
  output logic [ROB_W-1:0]  iss_rob
);
  localparam logic [SLOTS-1:0] ONE = {{(SLOTS-1){1'b0}}, 1'b1};

  logic [SLOTS-1:0]  slot_occ;
  logic [SLOTS-1:0]  slot_rdy;
  logic [SLOTS-1:0]  free_vec;
  logic [SLOTS-1:0]  first_free;
  logic [SLOTS-1:0]  alloc_oh;
  logic [SLOTS-1:0]  pick_oh;
  logic [SLOTS-1:0]  release_vec;
  logic              accept;
  logic              take;

  logic [OP_W-1:0]   s_op  [SLOTS];
  logic [DATA_W-1:0] s_s1  [SLOTS];
  logic [DATA_W-1:0] s_s2  [SLOTS];
  logic [TAG_W-1:0]  s_dst [SLOTS];
  logic [ROB_W-1:0]  s_rob [SLOTS];

  logic [OP_W-1:0]   sel_op;
  logic [DATA_W-1:0] sel_s1;
  logic [DATA_W-1:0] sel_s2;
  logic [TAG_W-1:0]  sel_dst;
  logic [ROB_W-1:0]  sel_rob;

  // allocation: lowest free slot
  assign free_vec   = ~slot_occ;
  assign first_free = free_vec & (~free_vec + ONE);
  assign disp_ready = |free_vec;
  assign accept     = disp_valid && disp_ready;
  assign alloc_oh   = accept ? first_free : '0;

  // move the pick to the issue stage whenever that stage frees up
  assign take        = (|pick_oh) && (!iss_valid || iss_ready);
  assign release_vec = take ? pick_oh : '0;

  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    rsv_slot #(
      .OP_W(OP_W), .DATA_W(DATA_W), .TAG_W(TAG_W), .ROB_W(ROB_W)
    ) u_slot (
      .clk(clk), .rst(rst),
      .alloc(alloc_oh[i]), .release_en(release_vec[i]),
      .d_op(disp_op),
      .d_s1_have(disp_s1_have), .d_s1(disp_s1),
      .d_s2_have(disp_s2_have), .d_s2(disp_s2),
      .d_dst(disp_dst), .d_rob(disp_rob),
      .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_value(bc_value),
      .occupied(slot_occ[i]), .ready(slot_rdy[i]),
      .op(s_op[i]), .s1(s_s1[i]), .s2(s_s2[i]),
      .dst(s_dst[i]), .rob(s_rob[i])
    );
  end

  rsv_age_pick #(.SLOTS(SLOTS)) u_pick (
    .clk(clk), .rst(rst),
    .alloc_oh(alloc_oh), .occ(slot_occ),
    .req(slot_rdy), .grant_oh(pick_oh)
  );

  // one-hot read of the picked slot
  always_comb begin
    sel_op  = '0;
    sel_s1  = '0;
    sel_s2  = '0;
    sel_dst = '0;
    sel_rob = '0;
    for (int i = 0; i < SLOTS; i++) begin
      if (pick_oh[i]) begin
        sel_op  = sel_op  | s_op[i];
        sel_s1  = sel_s1  | s_s1[i];
        sel_s2  = sel_s2  | s_s2[i];
        sel_dst = sel_dst | s_dst[i];
        sel_rob = sel_rob | s_rob[i];
      end
    end
  end

  // registered issue stage
  always_ff @(posedge clk) begin
    if (rst) begin
      iss_valid <= 1'b0;
    end else if (take) begin
      iss_valid <= 1'b1;
    end else if (iss_ready) begin
      iss_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (take) begin
      iss_op  <= sel_op;
      iss_s1  <= sel_s1;
      iss_s2  <= sel_s2;
      iss_dst <= sel_dst;
      iss_rob <= sel_rob;
    end
  end
endmodule

// File: rtl/rsv_station_chk.sv
module rsv_station_chk #(
  parameter int SLOTS  = 8,
  parameter int OP_W   = 4,
  parameter int DATA_W = 16,
  parameter int TAG_W  = 6,
  parameter int ROB_W  = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              disp_valid,
  input logic              disp_ready,
  input logic              iss_valid,
  input logic              iss_ready,
  input logic [OP_W-1:0]   iss_op,
  input logic [DATA_W-1:0] iss_s1,
  input logic [DATA_W-1:0] iss_s2,
  input logic [TAG_W-1:0]  iss_dst,
  input logic [ROB_W-1:0]  iss_rob,
  input logic [SLOTS-1:0]  slot_occ,
  input logic [SLOTS-1:0]  slot_rdy,
  input logic [SLOTS-1:0]  pick_oh,
  input logic              take
);
  // R6: at most one slot selected
  assert_pick_onehot_R6: assert property (@(posedge clk) disable iff (rst)
    $onehot0(pick_oh));

  // R4: only slots with both flags set can be selected
  assert_pick_ready_R4: assert property (@(posedge clk) disable iff (rst)
    (pick_oh & ~slot_rdy) == '0);

  // R9: stalled issue stage holds its contents
  assert_issue_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (iss_valid && !iss_ready) |=> (iss_valid && $stable(iss_op) && $stable(iss_s1)
      && $stable(iss_s2) && $stable(iss_dst) && $stable(iss_rob)));

  // R7: a moved slot is empty afterwards
  assert_slot_freed_R7: assert property (@(posedge clk) disable iff (rst)
    take |=> ((slot_occ & $past(pick_oh)) == '0));

  // R1: an accepted dispatch without an issue raises occupancy by one
  assert_dispatch_fill_R1: assert property (@(posedge clk) disable iff (rst)
    (disp_valid && disp_ready && !take) |=>
      ($countones(slot_occ) == $past($countones(slot_occ)) + 1));
endmodule

bind rsv_station rsv_station_chk #(
  .SLOTS(SLOTS), .OP_W(OP_W), .DATA_W(DATA_W), .TAG_W(TAG_W), .ROB_W(ROB_W)
) chk_i (
  .clk(clk), .rst(rst),
  .disp_valid(disp_valid), .disp_ready(disp_ready),
  .iss_valid(iss_valid), .iss_ready(iss_ready),
  .iss_op(iss_op), .iss_s1(iss_s1), .iss_s2(iss_s2),
  .iss_dst(iss_dst), .iss_rob(iss_rob),
  .slot_occ(slot_occ), .slot_rdy(slot_rdy),
  .pick_oh(pick_oh), .take(take)
);

// File: tb/rsv_station_tb_top.sv
module rsv_station_tb_top;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        disp_valid;
  logic        disp_ready;
  logic [3:0]  disp_op;
  logic        disp_s1_have;
  logic [15:0] disp_s1;
  logic        disp_s2_have;
  logic [15:0] disp_s2;
  logic [5:0]  disp_dst;
  logic [4:0]  disp_rob;
  logic        bc_valid;
  logic [5:0]  bc_tag;
  logic [15:0] bc_value;
  logic        iss_valid;
  logic        iss_ready;
  logic [3:0]  iss_op;
  logic [15:0] iss_s1;
  logic [15:0] iss_s2;
  logic [5:0]  iss_dst;
  logic [4:0]  iss_rob;

  int n_checks = 0;
  int n_err    = 0;

  // scoreboard keyed by reorder index
  bit          sb_pend [32];
  logic [3:0]  sb_op   [32];
  logic [15:0] sb_s1   [32];
  logic [15:0] sb_s2   [32];
  logic [5:0]  sb_dst  [32];

  always #(CLK_P/2) clk = ~clk;

  rsv_station dut_i (
    .clk(clk), .rst(rst),
    .disp_valid(disp_valid), .disp_ready(disp_ready), .disp_op(disp_op),
    .disp_s1_have(disp_s1_have), .disp_s1(disp_s1),
    .disp_s2_have(disp_s2_have), .disp_s2(disp_s2),
    .disp_dst(disp_dst), .disp_rob(disp_rob),
    .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_value(bc_value),
    .iss_valid(iss_valid), .iss_ready(iss_ready), .iss_op(iss_op),
    .iss_s1(iss_s1), .iss_s2(iss_s2), .iss_dst(iss_dst), .iss_rob(iss_rob)
  );

  function automatic logic [15:0] val_of(input logic [5:0] t);
    return 16'h3000 + 16'(t) * 16'd97;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic offer(input logic [3:0] op, input bit h1, input logic [15:0] f1,
                       input bit h2, input logic [15:0] f2,
                       input logic [5:0] dst, input logic [4:0] rob);
    disp_valid = 1'b1; disp_op = op;
    disp_s1_have = h1; disp_s1 = f1;
    disp_s2_have = h2; disp_s2 = f2;
    disp_dst = dst; disp_rob = rob;
  endtask

  initial begin
    #(CLK_P * 150000);
    n_err++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
    $finish;
  end

  initial begin
    int dispatched;
    int issued;
    int bc_ctr;
    int rob_ctr;
    void'($urandom(32'd24681));
    rst = 1'b1; disp_valid = 1'b0; disp_op = '0; disp_s1_have = 1'b0; disp_s1 = '0;
    disp_s2_have = 1'b0; disp_s2 = '0; disp_dst = '0; disp_rob = '0;
    bc_valid = 1'b0; bc_tag = '0; bc_value = '0; iss_ready = 1'b0;
    for (int i = 0; i < 32; i++) sb_pend[i] = 1'b0;
    repeat (3) tick;
    rst = 1'b0;
    tick;

    // reset state
    chk("R11 disp_ready after reset", disp_ready, 1);
    chk("R11 iss_valid after reset", iss_valid, 0);

    // fill all slots, source 1 waits on tag 5 (upper field bits are junk)
    for (int i = 0; i < 8; i++) begin
      chk("R1 room before dispatch", disp_ready, 1);
      offer(4'(i), 1'b0, 16'hFF05, 1'b1, 16'h0100 + 16'(i), 6'(10 + i), 5'(i));
      tick;
    end
    disp_valid = 1'b0;
    chk("R8 disp_ready low when full", disp_ready, 0);
    // non-matching broadcast wakes nothing
    bc_valid = 1'b1; bc_tag = 6'd6; bc_value = 16'h7777;
    tick;
    bc_valid = 1'b0;
    tick;
    chk("R3 no wakeup on other tag", iss_valid, 0);
    chk("R4 nothing issues while waiting", iss_valid, 0);
    // offer while full is not taken
    offer(4'hF, 1'b1, 16'h1, 1'b1, 16'h2, 6'd63, 5'd31);
    tick;
    disp_valid = 1'b0;
    // matching broadcast wakes all eight
    bc_valid = 1'b1; bc_tag = 6'd5; bc_value = 16'hBEEF;
    tick;
    bc_valid = 1'b0;
    tick;
    chk("R6 oldest issues first", iss_valid ? 32'(iss_rob) : 32'hFFFF, 0);
    chk("R3 captured value src1", iss_s1, 16'hBEEF);
    chk("R3 ready src2 kept", iss_s2, 16'h0100);
    chk("R7 slot reusable after move", disp_ready, 1);
    repeat (3) tick;
    chk("R9 stalled issue holds rob", iss_rob, 0);
    chk("R9 stalled issue holds valid", iss_valid, 1);
    iss_ready = 1'b1;
    for (int k = 1; k < 8; k++) begin
      tick;
      chk("R6 dispatch order", iss_valid ? 32'(iss_rob) : 32'hFFFF, 32'(k));
      chk("R3 each entry captured", iss_s1, 16'hBEEF);
      chk("R1 opcode stored", iss_op, 32'(k));
      chk("R1 destination stored", iss_dst, 32'(10 + k));
    end
    tick;
    chk("R1 full-time offer was dropped", iss_valid, 0);

    // latency of a ready dispatch
    offer(4'h3, 1'b1, 16'hA1A1, 1'b1, 16'hB2B2, 6'd40, 5'd20);
    tick;
    disp_valid = 1'b0;
    chk("R10 not visible after one edge", iss_valid, 0);
    tick;
    chk("R10 visible after two edges", iss_valid ? 32'(iss_rob) : 32'hFFFF, 20);
    chk("R2 value flag keeps field", iss_s1, 16'hA1A1);
    tick;

    // same-cycle broadcast and dispatch
    offer(4'h4, 1'b0, 16'h0009, 1'b0, 16'hC009, 6'd41, 5'd21);
    bc_valid = 1'b1; bc_tag = 6'd9; bc_value = 16'h1234;
    tick;
    disp_valid = 1'b0; bc_valid = 1'b0;
    tick;
    chk("R5 same-cycle wake issues", iss_valid ? 32'(iss_rob) : 32'hFFFF, 21);
    chk("R5 src1 took broadcast", iss_s1, 16'h1234);
    chk("R5 src2 took broadcast", iss_s2, 16'h1234);
    tick;

    // age order differs from slot order
    iss_ready = 1'b0;
    offer(4'h1, 1'b0, 16'h0003, 1'b1, 16'h0011, 6'd1, 5'd1);  tick;
    offer(4'h2, 1'b0, 16'h0004, 1'b1, 16'h0022, 6'd2, 5'd2);  tick;
    offer(4'h3, 1'b0, 16'h0003, 1'b1, 16'h0033, 6'd3, 5'd3);  tick;
    disp_valid = 1'b0;
    bc_valid = 1'b1; bc_tag = 6'd4; bc_value = val_of(6'd4);
    tick;
    bc_valid = 1'b0;
    tick;
    chk("R4 woken entry issues", iss_valid ? 32'(iss_rob) : 32'hFFFF, 2);
    offer(4'h4, 1'b0, 16'h0003, 1'b1, 16'h0044, 6'd4, 5'd4);  tick;
    disp_valid = 1'b0;
    bc_valid = 1'b1; bc_tag = 6'd3; bc_value = val_of(6'd3);
    tick;
    bc_valid = 1'b0; iss_ready = 1'b1;
    tick;
    chk("R6 age order first", iss_rob, 1);
    chk("R3 age test value", iss_s1, val_of(6'd3));
    tick;
    chk("R6 age order second", iss_rob, 3);
    tick;
    chk("R6 age order third (reused slot)", iss_rob, 4);
    tick;
    chk("R7 drained", iss_valid, 0);

    // random traffic against scoreboard
    dispatched = 0; issued = 0; bc_ctr = 0; rob_ctr = 0;
    for (int cyc = 0; cyc < 4000; cyc++) begin
      bit drain;
      drain = (cyc >= 3000);
      iss_ready = drain ? 1'b1 : ($urandom_range(9, 0) < 7);
      if (iss_valid && iss_ready) begin
        n_checks++;
        if (!sb_pend[iss_rob] || iss_op !== sb_op[iss_rob] || iss_s1 !== sb_s1[iss_rob]
            || iss_s2 !== sb_s2[iss_rob] || iss_dst !== sb_dst[iss_rob]) begin
          n_err++;
          $display("FAIL R3/R4 random issue rob=%0d actual=%0h/%0h expected=%0h/%0h",
                   iss_rob, iss_s1, iss_s2, sb_s1[iss_rob], sb_s2[iss_rob]);
        end
        sb_pend[iss_rob] = 1'b0;
        issued++;
      end
      bc_valid = drain ? 1'b1 : ($urandom_range(9, 0) < 7);
      bc_tag   = 6'(bc_ctr);
      bc_value = val_of(6'(bc_ctr));
      if (bc_valid) bc_ctr++;
      disp_valid = 1'b0;
      if (!drain && $urandom_range(9, 0) < 6 && !sb_pend[rob_ctr]) begin
        bit          h1, h2;
        logic [15:0] f1, f2;
        logic [5:0]  t1, t2;
        h1 = ($urandom_range(1, 0) == 1);
        h2 = ($urandom_range(1, 0) == 1);
        t1 = 6'($urandom_range(63, 0));
        t2 = 6'($urandom_range(63, 0));
        f1 = h1 ? 16'($urandom) : {10'($urandom), t1};
        f2 = h2 ? 16'($urandom) : {10'($urandom), t2};
        offer(4'($urandom), h1, f1, h2, f2, 6'($urandom), 5'(rob_ctr));
        if (disp_ready) begin
          sb_pend[rob_ctr] = 1'b1;
          sb_op[rob_ctr]  = disp_op;
          sb_s1[rob_ctr]  = h1 ? f1 : val_of(t1);
          sb_s2[rob_ctr]  = h2 ? f2 : val_of(t2);
          sb_dst[rob_ctr] = disp_dst;
          rob_ctr = (rob_ctr + 1) % 32;
          dispatched++;
        end
      end
      tick;
    end
    disp_valid = 1'b0; bc_valid = 1'b0;
    chk("R7 every dispatch issued once", 32'(issued), 32'(dispatched));
    chk("R7 station empty at end", disp_ready && !iss_valid, 1);

    $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
    $finish;
  end
endmodule